// File: doc/BRIEF.md
# Turn-Synchronous Double-Buffered Message Transmitter

This block sends one broadcast message of fixed length on every revolution tick of a machine. A message is a series of command words. Each word carries an 8-bit sub-address and an 8-bit data byte. A host writes the words for the next turn into one of two message banks (the fill bank) while the other bank (the send bank) is streamed out. When a tick arrives, the block waits a programmable number of bunch-clock cycles. It then shifts the message out serially and exchanges the roles of the two banks. The turn period is not built into the design: messages are paced only by the tick input.

The host sees which bank is open for writing (`fill_bank`) and how many words it already holds (`fill_count`). Writes go to consecutive positions in that bank. If the fill bank is not complete when a tick arrives, the previous message is sent again and an underrun is flagged. A tick that arrives while a message is still being delayed or sent is flagged as an overrun and is otherwise ignored.

The sequencer has three states. IDLE waits for a tick. DELAY counts down the phase offset. SEND shifts the frames out. The transitions are:
- IDLE→SEND on a tick when the phase is 0.
- IDLE→DELAY on a tick when the phase is non-zero.
- DELAY→SEND when the count reaches its last cycle.
- SEND→SEND at each word boundary, which loads the next word.
- SEND→IDLE after the last bit of the last word.

Top module: `turn_msg_tx`

## Requirements
- R1: On a tick accepted in IDLE with a complete fill bank (fill_count = MSG_WORDS), that bank becomes the send bank. `fill_bank` toggles and `fill_count` returns to 0.
- R2: Each accepted tick produces exactly one message. The message is MSG_WORDS frames of 19 bits each, sent back to back with `tx_valid` high for MSG_WORDS×19 consecutive cycles and low afterwards.
- R3: Each frame is sent MSB first as: start bit = 1, long-format flag = 1, sub-address[7:0], data[7:0], then a parity bit equal to the XOR of the 16 sub-address and data bits. `tx_word_start` is high exactly on the start bit.
- R4: If the tick is high in cycle T and `phase_dly` = P (sampled with the tick), the first start bit appears in cycle T+1+P.
- R5: A write is accepted only when `wr_bank` equals `fill_bank` and `fill_count` < MSG_WORDS. It stores {`wr_sub`,`wr_data`} at position `fill_count` and increments the count. Any other write raises `wr_reject` in the next cycle and changes neither the count nor any stored word.
- R6: A tick accepted in IDLE with an incomplete fill bank resends the last send bank unchanged and raises `underrun` in the next cycle. `fill_bank` and `fill_count` are left as they were. After reset the send bank holds all-zero words.
- R7: A tick that arrives in DELAY or SEND raises `overrun` in the next cycle. The current message completes unchanged, no further message is launched, and no bank swap occurs.
- R8: After reset, `tx_valid`, `tx_word_start`, `underrun`, `overrun` and `wr_reject` are low, `fill_bank` is 0 and `fill_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Active-low synchronous reset |
| turn_tick | input | 1 | Revolution tick, one cycle wide |
| phase_dly | input | PHASE_W | Phase offset in cycles, sampled with the tick |
| wr_en | input | 1 | Host write strobe |
| wr_bank | input | 1 | Bank the host intends to write |
| wr_sub | input | 8 | Sub-address of the written word |
| wr_data | input | 8 | Data byte of the written word |
| fill_bank | output | 1 | Bank currently open for writing |
| fill_count | output | $clog2(MSG_WORDS+1) | Words held in the fill bank |
| wr_reject | output | 1 | Pulse: last write refused |
| tx_bit | output | 1 | Serial output bit |
| tx_valid | output | 1 | Serial bit is valid |
| tx_word_start | output | 1 | Current bit is a frame start bit |
| underrun | output | 1 | Pulse: incomplete bank at tick, previous message resent |
| overrun | output | 1 | Pulse: tick arrived while busy |

## Verification
The main send path is tried in four ways:
- A message from the all-zero bank after reset. This gives frames whose parity bit is 0.
- Two different full patterns in alternate banks. These show that the bank roles really exchange and that data does not leak between banks.
- Phase values of 0, 1, 2, 3 and 7. These separate an off-by-one in the delay counter from a correct count.
- A partly filled bank at the tick. This shows that a resend of the old message is different from a send of the half-written one.

A tick injected in the middle of a send tells a design that restarts or swaps on a busy tick apart from one that only flags it. Writes to the wrong bank and to a full bank show that refusals leave the stored words untouched.

// File: rtl/turn_msg_tx_pkg.sv
package turn_msg_tx_pkg;
    localparam int SUB_W   = 8;
    localparam int DAT_W   = 8;
    localparam int FRAME_W = 2 + SUB_W + DAT_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DELAY,
        ST_SEND
    } seq_state_e;

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic [DAT_W-1:0] dat;
    } msg_word_t;
endpackage

// File: rtl/pp_bank_store.sv
module pp_bank_store
    import turn_msg_tx_pkg::*;
#(
    parameter int MSG_WORDS = 32,
    localparam int IDX_W = $clog2(MSG_WORDS),
    localparam int CNT_W = $clog2(MSG_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  msg_word_t        wr_word,
    input  logic             swap,
    input  logic             rd_bank,
    input  logic [IDX_W-1:0] rd_idx,
    output msg_word_t        rd_word,
    output logic             fill_sel,
    output logic [CNT_W-1:0] fill_count,
    output logic             fill_full,
    output logic             wr_reject
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(MSG_WORDS);

    msg_word_t mem_q [2][MSG_WORDS];
    logic      accept;

    assign fill_full = (fill_count == FULL_CNT);
    assign accept    = wr_en && (wr_bank == fill_sel) && !fill_full;
    assign rd_word   = mem_q[rd_bank][rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin
                for (int w = 0; w < MSG_WORDS; w++) begin
                    mem_q[b][w] <= '0;
                end
            end
            fill_sel   <= 1'b0;
            fill_count <= '0;
            wr_reject  <= 1'b0;
        end else begin
            wr_reject <= wr_en && !accept;
            if (accept) begin
                mem_q[fill_sel][fill_count[IDX_W-1:0]] <= wr_word;
            end
            if (swap) begin
                fill_sel   <= ~fill_sel;
                fill_count <= '0;
            end else if (accept) begin
                fill_count <= fill_count + 1'b1;
            end
        end
    end

    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= FULL_CNT);

    p_reject_keeps_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> (fill_count == $past(fill_count)) || (fill_count == '0));

    p_swap_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fill_sel) |-> (fill_count == '0));
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
    import turn_msg_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  logic      shift,
    input  msg_word_t word_in,
    output logic      ser_bit
);
    logic [FRAME_W-1:0] sh_q;
    logic               par;

    assign par     = ^{word_in.sub, word_in.dat};
    assign ser_bit = sh_q[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= {1'b1, 1'b1, word_in.sub, word_in.dat, par};
        end else if (shift) begin
            sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
        end
    end

    p_no_load_and_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));
endmodule

// File: rtl/turn_sequencer.sv
module turn_sequencer
    import turn_msg_tx_pkg::*;
#(
    parameter int MSG_WORDS = 32,
    parameter int PHASE_W   = 12,
    localparam int IDX_W = $clog2(MSG_WORDS),
    localparam int BIT_W = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               turn_tick,
    input  logic [PHASE_W-1:0] phase_dly,
    input  logic               fill_full,
    input  logic               fill_sel,
    output logic               swap,
    output logic               ser_load,
    output logic               ser_shift,
    output logic               rd_bank,
    output logic [IDX_W-1:0]   rd_idx,
    output logic               tx_valid,
    output logic               tx_word_start,
    output logic               underrun,
    output logic               overrun
);
    localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(MSG_WORDS - 1);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_W - 1);

    seq_state_e         state_q, state_d;
    logic [PHASE_W-1:0] dly_q, dly_d;
    logic [BIT_W-1:0]   bit_q, bit_d;
    logic [IDX_W-1:0]   word_q, word_d;
    logic               tick_take, tick_late;

    // state register and registered flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            dly_q    <= '0;
            bit_q    <= '0;
            word_q   <= '0;
            underrun <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            state_q  <= state_d;
            dly_q    <= dly_d;
            bit_q    <= bit_d;
            word_q   <= word_d;
            underrun <= tick_take && !fill_full;
            overrun  <= tick_late;
        end
    end

    // next state and datapath control
    always_comb begin
        state_d   = state_q;
        dly_d     = dly_q;
        bit_d     = bit_q;
        word_d    = word_q;
        swap      = 1'b0;
        ser_load  = 1'b0;
        ser_shift = 1'b0;
        rd_bank   = ~fill_sel;
        rd_idx    = word_q;
        tick_take = 1'b0;
        tick_late = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (turn_tick) begin
                    tick_take = 1'b1;
                    swap      = fill_full;
                    rd_bank   = fill_full ? fill_sel : ~fill_sel;
                    rd_idx    = '0;
                    word_d    = '0;
                    bit_d     = '0;
                    if (phase_dly == '0) begin
                        ser_load = 1'b1;
                        state_d  = ST_SEND;
                    end else begin
                        dly_d   = phase_dly;
                        state_d = ST_DELAY;
                    end
                end
            end
            ST_DELAY: begin
                tick_late = turn_tick;
                rd_idx    = '0;
                if (dly_q == PHASE_W'(1)) begin
                    ser_load = 1'b1;
                    state_d  = ST_SEND;
                end else begin
                    dly_d = dly_q - 1'b1;
                end
            end
            ST_SEND: begin
                tick_late = turn_tick;
                if (bit_q == LAST_BIT) begin
                    bit_d = '0;
                    if (word_q == LAST_WORD) begin
                        state_d = ST_IDLE;
                    end else begin
                        ser_load = 1'b1;
                        rd_idx   = word_q + 1'b1;
                        word_d   = word_q + 1'b1;
                    end
                end else begin
                    ser_shift = 1'b1;
                    bit_d     = bit_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Moore outputs
    always_comb begin
        tx_valid      = (state_q == ST_SEND);
        tx_word_start = (state_q == ST_SEND) && (bit_q == '0);
    end

    p_msg_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_valid) |-> $past(bit_q == LAST_BIT && word_q == LAST_WORD));

    p_overrun_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(state_q != ST_IDLE));

    p_delay_from_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DELAY && $past(state_q) == ST_IDLE) |-> $past(turn_tick));
endmodule

// File: rtl/turn_msg_tx.sv
module turn_msg_tx
    import turn_msg_tx_pkg::*;
#(
    parameter int MSG_WORDS = 32,
    parameter int PHASE_W   = 12,
    localparam int IDX_W = $clog2(MSG_WORDS),
    localparam int CNT_W = $clog2(MSG_WORDS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               turn_tick,
    input  logic [PHASE_W-1:0] phase_dly,
    input  logic               wr_en,
    input  logic               wr_bank,
    input  logic [SUB_W-1:0]   wr_sub,
    input  logic [DAT_W-1:0]   wr_data,
    output logic               fill_bank,
    output logic [CNT_W-1:0]   fill_count,
    output logic               wr_reject,
    output logic               tx_bit,
    output logic               tx_valid,
    output logic               tx_word_start,
    output logic               underrun,
    output logic               overrun
);
    msg_word_t        wr_word, rd_word;
    logic             swap, ser_load, ser_shift, rd_bank, fill_full;
    logic [IDX_W-1:0] rd_idx;

    assign wr_word.sub = wr_sub;
    assign wr_word.dat = wr_data;

    pp_bank_store #(.MSG_WORDS(MSG_WORDS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_bank    (wr_bank),
        .wr_word    (wr_word),
        .swap       (swap),
        .rd_bank    (rd_bank),
        .rd_idx     (rd_idx),
        .rd_word    (rd_word),
        .fill_sel   (fill_bank),
        .fill_count (fill_count),
        .fill_full  (fill_full),
        .wr_reject  (wr_reject)
    );

    turn_sequencer #(.MSG_WORDS(MSG_WORDS), .PHASE_W(PHASE_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .turn_tick     (turn_tick),
        .phase_dly     (phase_dly),
        .fill_full     (fill_full),
        .fill_sel      (fill_bank),
        .swap          (swap),
        .ser_load      (ser_load),
        .ser_shift     (ser_shift),
        .rd_bank       (rd_bank),
        .rd_idx        (rd_idx),
        .tx_valid      (tx_valid),
        .tx_word_start (tx_word_start),
        .underrun      (underrun),
        .overrun       (overrun)
    );

    frame_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ser_load),
        .shift   (ser_shift),
        .word_in (rd_word),
        .ser_bit (tx_bit)
    );

    p_start_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_word_start |-> (tx_bit && tx_valid));

    p_long_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_word_start) && tx_valid) |-> tx_bit);

    p_swap_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && $past(tx_valid)) |-> $stable(fill_bank));
endmodule

// File: tb/turn_msg_tx_tb.sv
module turn_msg_tx_tb;
    localparam int NW = 32;
    localparam int PW = 12;
    localparam int FW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          turn_tick = 1'b0;
    logic [PW-1:0] phase_dly = '0;
    logic          wr_en = 1'b0;
    logic          wr_bank = 1'b0;
    logic [7:0]    wr_sub = '0;
    logic [7:0]    wr_data = '0;
    logic          fill_bank, wr_reject, tx_bit, tx_valid, tx_word_start;
    logic          underrun, overrun;
    logic [5:0]    fill_count;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] m_sub [2][NW];
    logic [7:0] m_dat [2][NW];
    int         m_fill = 0;
    int         m_cnt = 0;

    always #2 clk = ~clk;

    turn_msg_tx #(.MSG_WORDS(NW), .PHASE_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .turn_tick(turn_tick), .phase_dly(phase_dly),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_sub(wr_sub), .wr_data(wr_data),
        .fill_bank(fill_bank), .fill_count(fill_count), .wr_reject(wr_reject),
        .tx_bit(tx_bit), .tx_valid(tx_valid), .tx_word_start(tx_word_start),
        .underrun(underrun), .overrun(overrun)
    );

    function automatic logic [FW-1:0] frame_of(input logic [7:0] s, input logic [7:0] d);
        return {2'b11, s, d, ^{s, d}};
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic write_word(input logic bank, input logic [7:0] s, input logic [7:0] d,
                              input bit expect_rej);
        @(negedge clk);
        wr_en = 1'b1; wr_bank = bank; wr_sub = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R5", "wr_reject", wr_reject, expect_rej);
        if (!expect_rej) begin
            m_sub[bank][m_cnt] = s;
            m_dat[bank][m_cnt] = d;
            m_cnt++;
        end
    endtask

    // Launches a turn, checks phase and flags, captures and compares the message.
    task automatic launch(input int p, input int bank, input bit exp_under, input int inj);
        int k;
        logic [FW-1:0] fr;
        phase_dly = PW'(p);
        @(negedge clk);
        turn_tick = 1'b1;
        @(negedge clk);
        turn_tick = 1'b0;
        chk("R6", "underrun flag", underrun, exp_under);
        k = 1;
        while (!tx_valid && k < 5000) begin
            @(negedge clk);
            k++;
        end
        chk("R4", "cycles tick to first bit", k, p + 1);
        for (int w = 0; w < NW; w++) begin
            fr = '0;
            for (int b = 0; b < FW; b++) begin
                if (!tx_valid) begin
                    chk("R2", "tx_valid inside message", 0, 1);
                end
                if (b == 0) chk("R3", "word start strobe", tx_word_start, 1);
                fr = {fr[FW-2:0], tx_bit};
                if (turn_tick) begin
                    turn_tick = 1'b0;
                    chk("R7", "overrun flag", overrun, 1);
                end
                if (w * FW + b == inj) turn_tick = 1'b1;
                @(negedge clk);
            end
            chk("R3", $sformatf("frame %0d", w), fr, frame_of(m_sub[bank][w], m_dat[bank][w]));
        end
        chk("R2", "tx_valid after message", tx_valid, 0);
    endtask

    task automatic t_reset;
        chk("R8", "tx_valid", tx_valid, 0);
        chk("R8", "tx_word_start", tx_word_start, 0);
        chk("R8", "fill_bank", fill_bank, 0);
        chk("R8", "fill_count", fill_count, 0);
        chk("R8", "flags", {underrun, overrun, wr_reject}, 0);
    endtask

    task automatic t_empty_underrun;
        launch(0, 1, 1'b1, -1);
        chk("R6", "fill_bank kept", fill_bank, 0);
    endtask

    task automatic fill_bank_full(input int bank, input int seed);
        for (int i = m_cnt; i < NW; i++) begin
            write_word(bank[0], 8'(i * 3 + seed), 8'(i ^ (seed * 37)), 1'b0);
        end
        chk("R5", "fill_count full", fill_count, NW);
    endtask

    task automatic t_fill_and_reject;
        fill_bank_full(0, 1);
        write_word(1'b1, 8'h55, 8'h66, 1'b1);
        write_word(1'b0, 8'h77, 8'h88, 1'b1);
        chk("R5", "count after rejects", fill_count, NW);
    endtask

    task automatic t_swap_send;
        launch(0, 0, 1'b0, -1);
        chk("R1", "fill_bank toggled", fill_bank, 1);
        chk("R1", "fill_count cleared", fill_count, 0);
        m_fill = 1; m_cnt = 0;
    endtask

    task automatic t_phase_seven;
        fill_bank_full(1, 5);
        launch(7, 1, 1'b0, -1);
        chk("R1", "fill_bank back to 0", fill_bank, 0);
        m_fill = 0; m_cnt = 0;
    endtask

    task automatic t_partial_underrun;
        for (int i = 0; i < 10; i++) begin
            write_word(1'b0, 8'(200 + i), 8'(i * 11), 1'b0);
        end
        launch(3, 1, 1'b1, -1);
        chk("R6", "fill_bank unchanged", fill_bank, 0);
        chk("R6", "fill_count unchanged", fill_count, 10);
        fill_bank_full(0, 9);
        launch(1, 0, 1'b0, -1);
        m_fill = 1; m_cnt = 0;
    endtask

    task automatic t_overrun;
        fill_bank_full(1, 13);
        launch(2, 1, 1'b0, 100);
        chk("R7", "fill_bank after busy tick", fill_bank, 0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tx_valid) begin
                chk("R7", "no relaunch", tx_valid, 0);
                break;
            end
        end
        chk("R7", "idle after message", tx_valid, 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 2; b++) begin
            for (int w = 0; w < NW; w++) begin
                m_sub[b][w] = '0;
                m_dat[b][w] = '0;
            end
        end
        repeat (4) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_empty_underrun;
        t_fill_and_reject;
        t_swap_send;
        t_phase_seven;
        t_partial_underrun;
        t_overrun;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule